// File: doc/BRIEF.md
# Instruction Prefix Merging Pre-Decoder

This block sits between the fetch buffer and the main instruction decoder. Each cycle it looks at a window of up to three 32-bit words. A prefix word carries no operation of its own. The block recognises such words by a fixed opcode value in their low bits and folds them, in the same step, into the instruction that follows. The main decoder then gets one bundle. The bundle holds the base instruction word, the group length in words (which the fetch pointer advances by), a prefix-present flag, the raw payload bits from the prefixes, and a sign-extended immediate. In that immediate the prefix payload sits above the base instruction's own 12-bit immediate.

A group never spans more than 96 bits. There are two cases where no bundle is issued. If the valid words end on prefixes, the block asks for more bytes and issues nothing. If a prefix precedes a base instruction that does not take prefixes, or the window fills with prefixes, the block flags an illegal encoding. All outputs are registered, so a window presented before a clock edge shows its result after that edge.

Top module: `pfx_merge_decoder`

## Requirements
- R1: While rst_n is low, and right after reset is released with no window presented, every output is zero.
- R2: A word whose bits [6:0] are not 7'h7B, in slot 0, issues alone. The outputs are out_vld=1, out_len=1, out_pfx=0, out_word equal to that word, out_payload=0, and out_imm equal to word bits [31:20] sign-extended to 64 bits.
- R3: A word with bits [6:0] equal to 7'h7B is a prefix. Its payload is bits [31:8]. It is never presented on out_word as an issued instruction.
- R4: One prefix followed by an accepting base issues with out_len=2 and out_pfx=1. out_payload holds the prefix payload in bits [23:0] and is zero above. out_imm is {payload, base[31:20]} (36 bits) sign-extended.
- R5: Two prefixes followed by an accepting base issue with out_len=3. out_payload is {first payload, second payload}, with the first in the high bits. out_imm is {first, second, base[31:20]} (60 bits) sign-extended.
- R6: Only bases with bits [6:0] equal to 7'h13 or 7'h03 accept prefixes. A prefix before any other base sets out_ill=1 and out_vld=0, and out_len is the group span including that base.
- R7: Three prefixes filling the whole window set out_ill=1 with out_len=3.
- R8: When all valid words are prefixes and the window is not full, out_stall=1, out_vld=0 and out_len=0.
- R9: Only the first in_cnt words are considered. Words beyond in_cnt have no effect. in_cnt=0 gives no vld, stall or ill.
- R10: Results appear exactly one clock after the window is sampled. out_len never exceeds the in_cnt it was sampled with.
- R11: At most one of out_vld, out_stall and out_ill is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_win | input | 96 | Fetch window; slot 0 in bits [31:0] |
| in_cnt | input | 2 | Number of valid words, counted from slot 0 |
| out_vld | output | 1 | Merged bundle issued |
| out_stall | output | 1 | Need more bytes; nothing issued |
| out_ill | output | 1 | Illegal prefix encoding |
| out_len | output | 2 | Words consumed by the group |
| out_pfx | output | 1 | Bundle carries at least one prefix |
| out_word | output | 32 | Base instruction word |
| out_payload | output | 48 | Concatenated prefix payload, right-aligned |
| out_imm | output | 64 | Merged, sign-extended immediate |

## Verification
Every cycle, the assertions check that the three result flags exclude each other and that a stall carries no length. They also check that a prefix-free bundle is one word long, that a prefixed one is longer, that no issued word carries the prefix opcode, and that the length stays within the valid count sampled the cycle before. The bench scenarios alone show the values: the exact merged immediates and their sign extension, the payload order, which bases accept prefixes, and that words past the valid count are ignored.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   // class of one window slot
   typedef struct packed {
      logic is_pfx;
      logic accepts;
   } slot_cls_t;

   // outcome of grouping the window
   typedef enum logic [1:0] {
      GRP_IDLE  = 2'd0,
      GRP_ISSUE = 2'd1,
      GRP_STALL = 2'd2,
      GRP_BAD   = 2'd3
   } grp_kind_t;

endpackage

// File: rtl/pfx_slot_classify.sv
module pfx_slot_classify
   import pfx_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 7,
   parameter int PAY_W  = 24,
   parameter logic [OPC_W-1:0] PFX_OPC  = 7'h7B,
   parameter logic [OPC_W-1:0] ACC_OPC0 = 7'h13,
   parameter logic [OPC_W-1:0] ACC_OPC1 = 7'h03
) (
   input  logic [WORD_W-1:0] word_i,
   output slot_cls_t         cls_o,
   output logic [PAY_W-1:0]  pay_o
);

   initial begin
      if (PAY_W + OPC_W > WORD_W)
         $error("payload and opcode do not fit in one word");
   end

   logic [OPC_W-1:0] opc;
   assign opc = word_i[OPC_W-1:0];

   always_comb begin
      cls_o.is_pfx  = (opc == PFX_OPC);
      cls_o.accepts = (opc == ACC_OPC0) || (opc == ACC_OPC1);
   end

   assign pay_o = word_i[WORD_W-1 -: PAY_W];

endmodule

// File: rtl/pfx_group_ctl.sv
module pfx_group_ctl
   import pfx_pkg::*;
#(
   parameter int NSLOT = 3,
   parameter int CNT_W = $clog2(NSLOT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  slot_cls_t [NSLOT-1:0]  cls_i,
   input  logic [CNT_W-1:0]       cnt_i,
   output grp_kind_t              kind_o,
   output logic [CNT_W-1:0]       len_o,
   output logic [CNT_W-1:0]       lead_o
);

   int eff;
   int lead;
   logic run;

   always_comb begin
      eff = (int'(cnt_i) > NSLOT) ? NSLOT : int'(cnt_i);
      lead = 0;
      run  = 1'b1;
      for (int i = 0; i < NSLOT; i++) begin
         if (run && (i < eff) && cls_i[i].is_pfx)
            lead = lead + 1;
         else
            run = 1'b0;
      end
      kind_o = GRP_IDLE;
      len_o  = '0;
      if (eff == 0) begin
         kind_o = GRP_IDLE;
      end else if (lead < eff) begin
         len_o = CNT_W'(lead + 1);
         if (lead == 0 || cls_i[lead].accepts)
            kind_o = GRP_ISSUE;
         else
            kind_o = GRP_BAD;
      end else if (eff == NSLOT) begin
         kind_o = GRP_BAD;
         len_o  = CNT_W'(NSLOT);
      end else begin
         kind_o = GRP_STALL;
      end
      lead_o = CNT_W'(lead);
   end

   // R6
   issue_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o == GRP_ISSUE) |-> (int'(len_o) == int'(lead_o) + 1));

   // R8
   stall_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o == GRP_STALL) |-> (lead_o == cnt_i && len_o == '0));

endmodule

// File: rtl/pfx_imm_merge.sv
module pfx_imm_merge #(
   parameter int NSLOT     = 3,
   parameter int WORD_W    = 32,
   parameter int PAY_W     = 24,
   parameter int IMM_W     = 12,
   parameter int OUT_IMM_W = 64,
   parameter int CNT_W     = $clog2(NSLOT + 1),
   parameter int MAXP      = NSLOT - 1,
   parameter int PAYT_W    = (MAXP > 0) ? MAXP * PAY_W : 1
) (
   input  logic [NSLOT*PAY_W-1:0] pay_i,
   input  logic [CNT_W-1:0]       npfx_i,
   input  logic [WORD_W-1:0]      base_i,
   output logic [PAYT_W-1:0]      payload_o,
   output logic [OUT_IMM_W-1:0]   imm_o
);

   localparam int RAW_W = PAYT_W + IMM_W;

   initial begin
      if (RAW_W > OUT_IMM_W)
         $error("merged immediate wider than output");
   end

   logic [PAYT_W-1:0]    pay;
   logic [RAW_W-1:0]     raw;
   logic [OUT_IMM_W-1:0] ext;
   int used;
   int sh;

   always_comb begin
      pay = '0;
      for (int i = 0; i < MAXP; i++) begin
         if (i < int'(npfx_i))
            pay = (pay << PAY_W) | PAYT_W'(pay_i[i*PAY_W +: PAY_W]);
      end
      raw  = (RAW_W'(pay) << IMM_W) | RAW_W'(base_i[WORD_W-1 -: IMM_W]);
      used = int'(npfx_i) * PAY_W + IMM_W;
      sh   = OUT_IMM_W - used;
      ext  = OUT_IMM_W'(raw) << sh;
      imm_o = OUT_IMM_W'($signed(ext) >>> sh);
      payload_o = pay;
   end

endmodule

// File: rtl/pfx_merge_decoder.sv
module pfx_merge_decoder
   import pfx_pkg::*;
#(
   parameter int NSLOT     = 3,
   parameter int WORD_W    = 32,
   parameter int OPC_W     = 7,
   parameter int PAY_W     = 24,
   parameter int IMM_W     = 12,
   parameter int OUT_IMM_W = 64,
   parameter logic [OPC_W-1:0] PFX_OPC  = 7'h7B,
   parameter logic [OPC_W-1:0] ACC_OPC0 = 7'h13,
   parameter logic [OPC_W-1:0] ACC_OPC1 = 7'h03
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NSLOT*WORD_W-1:0]               in_win,
   input  logic [$clog2(NSLOT+1)-1:0]            in_cnt,
   output logic                                  out_vld,
   output logic                                  out_stall,
   output logic                                  out_ill,
   output logic [$clog2(NSLOT+1)-1:0]            out_len,
   output logic                                  out_pfx,
   output logic [WORD_W-1:0]                     out_word,
   output logic [((NSLOT>1)?(NSLOT-1)*PAY_W:1)-1:0] out_payload,
   output logic [OUT_IMM_W-1:0]                  out_imm
);

   localparam int CNT_W  = $clog2(NSLOT + 1);
   localparam int MAXP   = NSLOT - 1;
   localparam int PAYT_W = (MAXP > 0) ? MAXP * PAY_W : 1;

   initial begin
      if (NSLOT * WORD_W > 96)
         $error("window exceeds 96 bits");
      if (NSLOT < 1)
         $error("window needs a slot");
      if (IMM_W > WORD_W - OPC_W)
         $error("base immediate overlaps opcode");
   end

   slot_cls_t [NSLOT-1:0]   cls;
   logic [NSLOT*PAY_W-1:0]  pays;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         pfx_slot_classify #(
            .WORD_W(WORD_W), .OPC_W(OPC_W), .PAY_W(PAY_W),
            .PFX_OPC(PFX_OPC), .ACC_OPC0(ACC_OPC0), .ACC_OPC1(ACC_OPC1)
         ) u_cls (
            .word_i(in_win[s*WORD_W +: WORD_W]),
            .cls_o (cls[s]),
            .pay_o (pays[s*PAY_W +: PAY_W])
         );
      end
   endgenerate

   grp_kind_t        kind;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] lead;

   pfx_group_ctl #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .cls_i (cls),
      .cnt_i (in_cnt),
      .kind_o(kind),
      .len_o (len),
      .lead_o(lead)
   );

   logic [WORD_W-1:0] base;

   always_comb begin
      base = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (int'(lead) == s)
            base = in_win[s*WORD_W +: WORD_W];
      end
   end

   logic [PAYT_W-1:0]    m_pay;
   logic [OUT_IMM_W-1:0] m_imm;
   logic [CNT_W-1:0]     npfx;

   assign npfx = (kind == GRP_ISSUE) ? lead : '0;

   pfx_imm_merge #(
      .NSLOT(NSLOT), .WORD_W(WORD_W), .PAY_W(PAY_W), .IMM_W(IMM_W),
      .OUT_IMM_W(OUT_IMM_W), .CNT_W(CNT_W), .MAXP(MAXP), .PAYT_W(PAYT_W)
   ) u_merge (
      .pay_i    (pays),
      .npfx_i   (npfx),
      .base_i   (base),
      .payload_o(m_pay),
      .imm_o    (m_imm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld     <= 1'b0;
         out_stall   <= 1'b0;
         out_ill     <= 1'b0;
         out_len     <= '0;
         out_pfx     <= 1'b0;
         out_word    <= '0;
         out_payload <= '0;
         out_imm     <= '0;
      end else begin
         out_vld     <= (kind == GRP_ISSUE);
         out_stall   <= (kind == GRP_STALL);
         out_ill     <= (kind == GRP_BAD);
         out_len     <= len;
         out_pfx     <= (kind == GRP_ISSUE) && (lead != '0);
         out_word    <= (kind == GRP_ISSUE) ? base : '0;
         out_payload <= (kind == GRP_ISSUE) ? m_pay : '0;
         out_imm     <= (kind == GRP_ISSUE) ? m_imm : '0;
      end
   end

   // R11
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_vld, out_stall, out_ill}));

   // R8
   stall_nolen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_stall |-> (out_len == '0));

   // R3
   pfx_not_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_word[OPC_W-1:0] != PFX_OPC));

   // R2
   plain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_pfx) |-> (out_len == CNT_W'(1)));

   // R4
   pfx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_pfx |-> (out_vld && out_len >= CNT_W'(2)));

   // R10
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld || out_ill) |-> (out_len <= $past(in_cnt)));

endmodule

// File: tb/pfx_merge_decoder_test.sv
module pfx_merge_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] in_win = '0;
   logic [1:0]  in_cnt = '0;
   logic        out_vld, out_stall, out_ill, out_pfx;
   logic [1:0]  out_len;
   logic [31:0] out_word;
   logic [47:0] out_payload;
   logic [63:0] out_imm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pfx_merge_decoder uut (
      .clk(clk), .rst_n(rst_n), .in_win(in_win), .in_cnt(in_cnt),
      .out_vld(out_vld), .out_stall(out_stall), .out_ill(out_ill),
      .out_len(out_len), .out_pfx(out_pfx), .out_word(out_word),
      .out_payload(out_payload), .out_imm(out_imm)
   );

   function automatic logic [31:0] pfx(input logic [23:0] p);
      return {p, 8'h7B};
   endfunction

   function automatic logic [31:0] base(input logic [11:0] imm, input logic [6:0] opc);
      return {imm, 13'h0ABC, opc};
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // present a window, then sample one clock later away from the edge
   task automatic apply(input logic [95:0] w, input logic [1:0] n);
      @(negedge clk);
      in_win = w;
      in_cnt = n;
      @(negedge clk);
   endtask

   task automatic expect_flags(input string req, input logic v, input logic s,
                               input logic i, input logic [1:0] l);
      cmp(req, "flags", {61'd0, out_vld, out_stall, out_ill}, {61'd0, v, s, i});
      cmp(req, "len", 64'(out_len), 64'(l));
   endtask

   task automatic t_reset();
      cmp("R1", "reset vld", 64'(out_vld), 0);
      cmp("R1", "reset word", 64'(out_word), 0);
      cmp("R1", "reset imm", out_imm, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_flags("R1", 0, 0, 0, 0);
   endtask

   task automatic t_plain();
      logic [31:0] b = base(12'h800, 7'h33);
      apply({pfx(24'h111111), pfx(24'h222222), b}, 2'd3);
      expect_flags("R2", 1, 0, 0, 1);
      cmp("R2", "pfx", 64'(out_pfx), 0);
      cmp("R2", "word", 64'(out_word), 64'(b));
      cmp("R2", "imm", out_imm, 64'hFFFF_FFFF_FFFF_F800);
      cmp("R2", "payload", 64'(out_payload), 0);
   endtask

   task automatic t_one_pfx();
      logic [31:0] b = base(12'h005, 7'h13);
      apply({32'h0, b, pfx(24'h800001)}, 2'd2);
      expect_flags("R4", 1, 0, 0, 2);
      cmp("R4", "pfx", 64'(out_pfx), 1);
      cmp("R3", "word is base", 64'(out_word), 64'(b));
      cmp("R4", "payload", 64'(out_payload), 64'h0000_0000_0080_0001);
      cmp("R4", "imm neg", out_imm, 64'hFFFF_FFF8_0000_1005);
      b = base(12'h800, 7'h03);
      apply({pfx(24'hFFFFFF), b, pfx(24'h000010)}, 2'd3);
      expect_flags("R4", 1, 0, 0, 2);
      cmp("R4", "imm pos", out_imm, 64'h0000_0000_0001_0800);
   endtask

   task automatic t_two_pfx();
      logic [31:0] b = base(12'hFFF, 7'h13);
      apply({b, pfx(24'hABCDEF), pfx(24'h123456)}, 2'd3);
      expect_flags("R5", 1, 0, 0, 3);
      cmp("R5", "payload", 64'(out_payload), 64'h0000_1234_56AB_CDEF);
      cmp("R5", "imm", out_imm, 64'h0123_456A_BCDE_FFFF);
      cmp("R5", "word", 64'(out_word), 64'(b));
      b = base(12'h000, 7'h03);
      apply({b, pfx(24'h000000), pfx(24'h800000)}, 2'd3);
      cmp("R5", "imm sign", out_imm, 64'hF800_0000_0000_0000);
   endtask

   task automatic t_bad_base();
      apply({32'h0, base(12'h001, 7'h33), pfx(24'h000001)}, 2'd2);
      expect_flags("R6", 0, 0, 1, 2);
      cmp("R6", "word hidden", 64'(out_word), 0);
      apply({base(12'h001, 7'h6F), pfx(24'h2), pfx(24'h1)}, 2'd3);
      expect_flags("R6", 0, 0, 1, 3);
   endtask

   task automatic t_three_pfx();
      apply({pfx(24'h3), pfx(24'h2), pfx(24'h1)}, 2'd3);
      expect_flags("R7", 0, 0, 1, 3);
   endtask

   task automatic t_stall();
      apply({base(12'h1, 7'h13), base(12'h1, 7'h13), pfx(24'h5)}, 2'd1);
      expect_flags("R8", 0, 1, 0, 0);
      apply({base(12'h1, 7'h13), pfx(24'h6), pfx(24'h5)}, 2'd2);
      expect_flags("R8", 0, 1, 0, 0);
   endtask

   task automatic t_count();
      apply({base(12'h7, 7'h13), base(12'h7, 7'h13), base(12'h7, 7'h13)}, 2'd0);
      expect_flags("R9", 0, 0, 0, 0);
      // slot 1 would make a legal pair, but only one word is valid
      apply({32'h0, base(12'h9, 7'h13), pfx(24'h4)}, 2'd1);
      expect_flags("R9", 0, 1, 0, 0);
      apply({pfx(24'h1), pfx(24'h2), base(12'h9, 7'h13)}, 2'd1);
      expect_flags("R9", 1, 0, 0, 1);
      cmp("R9", "imm", out_imm, 64'h9);
   endtask

   task automatic t_latency();
      @(negedge clk);
      in_win = {64'h0, base(12'h011, 7'h13)};
      in_cnt = 2'd1;
      @(negedge clk);
      in_win = {32'h0, base(12'h022, 7'h13), pfx(24'h000033)};
      in_cnt = 2'd2;
      cmp("R10", "first imm", out_imm, 64'h11);
      @(posedge clk);
      #1;
      cmp("R10", "second imm", out_imm, 64'h0000_0000_0033_022);
      cmp("R10", "second len", 64'(out_len), 2);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_one_pfx();
      t_two_pfx();
      t_bad_base();
      t_three_pfx();
      t_stall();
      t_count();
      t_latency();
      // R11 sweep: all flag combinations seen so far checked per step
      for (int k = 0; k < 8; k++) begin
         apply({pfx(24'(k)), (k[0] ? pfx(24'h1) : base(12'h3, 7'h13)),
                (k[1] ? pfx(24'h2) : base(12'h4, 7'h33))}, 2'(k % 4));
         cmp("R11", "exclusive", 64'($countones({out_vld, out_stall, out_ill}) <= 1), 1);
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule